// File: doc/BRIEF.md
# Programmable Interval Timer with Missed-Service Detection

This block is a periodic timer. It turns a shared base-rate tick into expiry events. A prescaler inside the block divides the tick by 64 to give one count unit. A down-counter then counts an 8-bit interval value in those units. When the count runs out, the timer reloads itself from the interval value and raises an elapsed flag.

If the period runs out again before the host has cleared that flag, a second error flag records that a service was missed. The host programs the interval through a load strobe and clears both flags with a single clear strobe. It arms an interrupt request through an enable register, and the request follows the elapsed flag while the enable is set.

With a 3 MHz source clock divided by 3, one count unit lasts 64 µs. With the clock divided by 4, one unit lasts about 85.3 µs. An interval of zero holds the timer idle.

Top module: `interval_timer`

## Requirements
- R1: After reset, `elapsed`, `err` and `irq` are 0, the interval is 0 so the timer is idle, and the interrupt enable is 0.
- R2: After a load of a nonzero value n, `elapsed` becomes 1 exactly after the (n·64)-th clock edge with `tick` high that follows the load edge, and not earlier.
- R3: After each expiry the counter reloads from the stored interval, so the next expiry follows another n·64 ticks with no host action.
- R4: An expiry that occurs while `elapsed` is already 1 sets `err` to 1.
- R5: A cycle with `clr` high returns `elapsed`, `err` and `irq` to 0 together, unless an expiry occurs in that same cycle.
- R6: When `clr` and an expiry fall in the same cycle, `elapsed` ends at 1 and `err` ends at 0.
- R7: `irq` is 1 exactly when `elapsed` is 1 and the interrupt enable is 1. A cycle with `ie_we` high stores `ie_d` as the enable.
- R8: While the stored interval is 0, the timer does not run and neither `elapsed` nor `err` is set. Loading 0 into a running timer stops it.
- R9: A load made partway through a period discards the progress so far, and counting restarts from the new value.
- R10: Only clock edges with `tick` high advance the prescaler. A load on an edge with `tick` high does not count that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base-rate enable from the shared prescaler |
| ld | input | 1 | Interval load strobe |
| ld_val | input | 8 | Interval value written on `ld` |
| clr | input | 1 | Clears elapsed, error and interrupt together |
| ie_we | input | 1 | Interrupt enable write strobe |
| ie_d | input | 1 | Interrupt enable value written on `ie_we` |
| elapsed | output | 1 | Period has run out since last clear |
| err | output | 1 | Period ran out twice without a clear |
| irq | output | 1 | Timer interrupt request |

## Verification
The assertions take `tick`, `ld`, `clr` and `ie_we` to be clean single-bit levels that are sampled only at the rising edge. A load is treated as a clean restart, which leaves no room for an expiry in the following cycle. The stimulus changes every input at the falling edge. Strobes are held for exactly one cycle, except where a test deliberately lines a clear up with an expiry. The pattern on `tick` is fixed at one value per cycle, so the count of qualifying edges is known.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W   = 8,
  parameter int PRE = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         ie_we,
  input  logic         ie_d,
  output logic         elapsed,
  output logic         err,
  output logic         irq
);
  localparam int PW = $clog2(PRE);

  logic [W-1:0]  ival, cnt;
  logic [PW-1:0] pre;
  logic          ie;

  wire run    = ival != '0;
  wire unit   = run && tick && (pre == PW'(PRE - 1));
  wire expire = !ld && unit && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival    <= '0;
      cnt     <= '0;
      pre     <= '0;
      ie      <= 1'b0;
      elapsed <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (ie_we) ie <= ie_d;
      if (ld) begin
        ival <= ld_val;
        cnt  <= ld_val;
        pre  <= '0;
      end else if (run && tick) begin
        pre <= unit ? '0 : pre + 1'b1;
        if (unit) cnt <= (cnt == W'(1)) ? ival : cnt - 1'b1;
      end
      elapsed <= expire | (elapsed & ~clr);
      err     <= (expire & elapsed & ~clr) | (err & ~clr);
    end
  end

  assign irq = ie & elapsed;

  a_r4_err_implies_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> elapsed);

  a_r5_clear_drops_err: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err);

  a_r4_err_rises_on_held_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(elapsed));

  a_r8_idle_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (ival == '0 && !ld) |=> !$rose(elapsed) && !$rose(err));

  a_r9_load_no_instant_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !$rose(elapsed));

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> elapsed);
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic clk = 0, rst_n = 0, tick = 1, ld = 0, clr = 0, ie_we = 0, ie_d = 0;
  logic [7:0] ld_val = 0;
  logic elapsed, err, irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_val(ld_val), .clr(clr),
    .ie_we(ie_we), .ie_d(ie_d), .elapsed(elapsed), .err(err), .irq(irq));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic edges(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_load(logic [7:0] v);
    ld = 1; ld_val = v; edges(1); ld = 0;
  endtask

  task automatic do_clr();
    clr = 1; edges(1); clr = 0;
  endtask

  task automatic set_ie(logic v);
    ie_we = 1; ie_d = v; edges(1); ie_we = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; edges(2); rst_n = 1; edges(1);
    check("R1 elapsed", elapsed, 0);
    check("R1 err", err, 0);
    check("R1 irq", irq, 0);
    edges(300);
    check("R1 idle after reset", elapsed, 0);
  endtask

  task automatic t_period();
    do_load(8'd2);
    edges(127); check("R2 before n*64", elapsed, 0);
    edges(1);   check("R2 at n*64", elapsed, 1);
    check("R7 irq off when disabled", irq, 0);
    do_clr();
    check("R5 elapsed cleared", elapsed, 0);
  endtask

  task automatic t_reload_err();
    do_load(8'd1);
    edges(64); check("R3 first expiry", elapsed, 1);
    check("R4 no err yet", err, 0);
    edges(63); check("R3 second not early", err, 0);
    edges(1);  check("R4 err on second expiry", err, 1);
    check("R3 reload gives second expiry", elapsed, 1);
    set_ie(1);
    check("R7 irq with enable", irq, 1);
    do_clr();
    check("R5 clear elapsed", elapsed, 0);
    check("R5 clear err", err, 0);
    check("R5 clear irq", irq, 0);
  endtask

  task automatic t_clr_collide();
    do_load(8'd1);
    edges(64); check("R6 setup", elapsed, 1);
    edges(63); clr = 1; edges(1); clr = 0;
    check("R6 elapsed kept", elapsed, 1);
    check("R6 err not set", err, 0);
    check("R7 irq follows", irq, 1);
    edges(64); check("R4 err after collide", err, 1);
    set_ie(0);
    check("R7 irq off after disable", irq, 0);
    do_clr();
  endtask

  task automatic t_stop();
    do_load(8'd0);
    edges(400);
    check("R8 zero interval idle", elapsed, 0);
    do_load(8'd1);
    edges(30);
    do_load(8'd0);
    edges(200);
    check("R8 stop mid-period", elapsed, 0);
    check("R8 no err", err, 0);
  endtask

  task automatic t_restart();
    do_load(8'd2);
    edges(100);
    do_load(8'd1);
    edges(63); check("R9 no early expiry", elapsed, 0);
    edges(1);  check("R9 expiry from restart", elapsed, 1);
    do_load(8'd0); do_clr();
  endtask

  task automatic t_tick_gate();
    do_load(8'd1);
    for (int i = 1; i <= 127; i++) begin
      tick = i[0];
      edges(1);
      if (i == 126) check("R10 half-rate not early", elapsed, 0);
    end
    check("R10 half-rate expiry", elapsed, 1);
    tick = 1;
    do_load(8'd0); do_clr();
  endtask

  initial begin
    t_reset();
    t_period();
    t_reload_err();
    t_clr_collide();
    t_stop();
    t_restart();
    t_tick_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule